// File: doc/BRIEF.md
# Refresh Interval Timer with Compare

This block sets the pace of periodic memory refresh. An 8-bit counter steps once for each cycle in which an external prescaler strobe is high. Each step compares the counter against a software-set constant. When the two are equal, the counter returns to zero, a compare flag is set and, if refresh is enabled, a refresh request goes to the memory controller. The request stays high until the controller acknowledges it with a single-cycle pulse. Requests never stack up: at most one refresh is ever pending.

The compare flag drives an interrupt output while interrupts are enabled. The flag is held apart from the refresh request, so software can count refresh periods through interrupts while refresh runs on its own. Software reaches the control, counter and constant registers through a plain 32-bit register bus. A write changes nothing unless its upper half carries the key 16'hA55A.

No data stream passes through the block, so there is no valid/ready interface. The prescaler strobe, the acknowledge, the request and the interrupt are plain level or pulse pins and are never held back. A bus write completes at the clock edge where `bus_wr` is sampled high. Reads are combinational from the registers.

Top module: `refresh_pacer`

## Requirements
- R1: While `tick` is high and the counter differs from the constant, the counter rises by one per cycle and wraps from 255 to 0 without setting the flag. While `tick` is low, the counter holds its value.
- R2: At a clock edge where `tick` is high and the counter equals the constant, the counter becomes 0 and the compare flag becomes 1. Both are visible from the following cycle.
- R3: When the refresh-enable bit is 1, a compare match sets `refresh_req` at the same edge. `refresh_req` then stays high until `refresh_ack` is sampled high.
- R4: At most one refresh is pending. A single `refresh_ack` pulse clears `refresh_req`, however many matches occurred while it was pending.
- R5: When a match and `refresh_ack` fall in the same cycle, `refresh_req` is 1 after that edge.
- R6: `irq` is high exactly when the compare flag is 1 and the interrupt-enable bit is 1. A keyed write of 0 to the flag bit clears the flag and leaves `refresh_req` unchanged. A write of 1 to the flag bit has no effect.
- R7: A write changes a register only when `bus_wdata[31:16]` equals 16'hA55A. Any other write leaves every register unchanged.
- R8: Register map by `bus_addr`:
  - Address 0 is control: bit 0 is refresh enable (read/write), bit 1 is interrupt enable (read/write), bit 2 is the compare flag.
  - Address 1 is the counter in bits 7:0. It is read-only, and writes to it are ignored.
  - Address 2 is the constant in bits 7:0 (read/write).
  - Address 3 reads 0. All unlisted bits read 0, and all registers reset to 0.
- R9: When the refresh-enable bit is 0, a compare match does not raise `refresh_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-enable strobe from the prescaler |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data; bits 31:16 carry the key |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| refresh_ack | input | 1 | One-cycle acknowledge from the memory controller |
| refresh_req | output | 1 | Pending refresh request |
| irq | output | 1 | Compare interrupt |

## Verification
Every result is due one edge after its cause. A tick or a write sampled at edge N shows up in the counter, flag, request and `irq` straight after edge N. `bus_rdata` follows `bus_addr` with no register in between. The bench therefore changes inputs on the falling edge, lets exactly one rising edge pass per stimulus, and reads outputs a short delay after the next falling edge, so each check falls in the first cycle where the new value is valid. The same-cycle acknowledge/match case and the many-period request/interrupt count are placed so that the edge where each must hold is known.

// File: rtl/refresh_pacer_pkg.sv
package refresh_pacer_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned KEY_W   = 16;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned NUM_REG = 3;
  localparam logic [KEY_W-1:0] WR_KEY = 16'hA55A;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CONST = 2'd2
  } reg_sel_e;

  localparam int unsigned BIT_REN  = 0;
  localparam int unsigned BIT_IE   = 1;
  localparam int unsigned BIT_FLAG = 2;
endpackage

// File: rtl/rp_key_gate.sv
module rp_key_gate
  import refresh_pacer_pkg::*;
#(
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned NREG = NUM_REG
) (
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [KEY_W-1:0] key,
  output logic [NREG-1:0]  we
);
  logic key_ok;
  assign key_ok = (key == WR_KEY);

  for (genvar i = 0; i < NREG; i++) begin : g_we
    assign we[i] = wr && key_ok && (addr == AW'(i));
  end
endmodule

// File: rtl/rp_interval_counter.sv
module rp_interval_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         match
);
  assign match = tick && (count == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (match) count <= '0;
    else if (tick)  count <= count + 1'b1;
  end
endmodule

// File: rtl/rp_sticky.sv
module rp_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/refresh_pacer.sv
module refresh_pacer
  import refresh_pacer_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              refresh_ack,
  output logic              refresh_req,
  output logic              irq
);
  localparam int unsigned PAD_W = BUS_W - CNT_W;

  logic [NUM_REG-1:0] we;
  logic [CNT_W-1:0]   cnt_q, cmp_q;
  logic               ren_q, ie_q, flag_q, match;
  logic               flag_clr;
  logic               unused_wdata;

  assign unused_wdata = ^bus_wdata[KEY_W-1:CNT_W];

  rp_key_gate #(.AW(ADDR_W), .NREG(NUM_REG)) u_gate (
    .wr   (bus_wr),
    .addr (bus_addr),
    .key  (bus_wdata[BUS_W-1:BUS_W-KEY_W]),
    .we   (we)
  );

  rp_interval_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .limit (cmp_q),
    .count (cnt_q),
    .match (match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ren_q <= 1'b0;
      ie_q  <= 1'b0;
      cmp_q <= '0;
    end else begin
      if (we[SEL_CTRL]) begin
        ren_q <= bus_wdata[BIT_REN];
        ie_q  <= bus_wdata[BIT_IE];
      end
      if (we[SEL_CONST]) cmp_q <= bus_wdata[CNT_W-1:0];
    end
  end

  assign flag_clr = we[SEL_CTRL] && !bus_wdata[BIT_FLAG];

  rp_sticky u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (match),
    .clr   (flag_clr),
    .q     (flag_q)
  );

  rp_sticky u_req (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (match && ren_q),
    .clr   (refresh_ack),
    .q     (refresh_req)
  );

  assign irq = flag_q && ie_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      SEL_CTRL: begin
        bus_rdata[BIT_REN]  = ren_q;
        bus_rdata[BIT_IE]   = ie_q;
        bus_rdata[BIT_FLAG] = flag_q;
      end
      SEL_COUNT: bus_rdata = {{PAD_W{1'b0}}, cnt_q};
      SEL_CONST: bus_rdata = {{PAD_W{1'b0}}, cmp_q};
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/refresh_pacer_checker.sv
module refresh_pacer_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             bus_wr,
  input logic [31:0]      bus_wdata,
  input logic             refresh_ack,
  input logic             refresh_req,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic             flag,
  input logic             ren
);
  // R1: counter steps when ticked without a match
  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != cmp) |=> cnt == $past(cnt) + 1'b1);
  // R1: counter holds without a tick
  assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  // R2: match clears the counter and sets the flag
  assert_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == cmp) |=> (cnt == '0 && flag));
  // R3: pending request held until acknowledged
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !refresh_ack) |=> refresh_req);
  // R4: acknowledge without a new match leaves nothing pending
  assert_ack_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_ack && !(tick && cnt == cmp)) |=> !refresh_req);
  // R6: flag clear does not disturb the request
  assert_flag_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flag) && !$past(refresh_ack)) |-> refresh_req == $past(refresh_req));
  // R6: interrupt needs the flag
  assert_irq_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
  // R7: unkeyed writes leave the constant alone
  assert_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata[31:16] != 16'hA55A) |=> $stable(cmp));
  // R9: no request rises while refresh is disabled
  assert_noreq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ren && !refresh_req) |=> !refresh_req);
endmodule

bind refresh_pacer refresh_pacer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .refresh_ack (refresh_ack),
  .refresh_req (refresh_req),
  .irq         (irq),
  .cnt         (cnt_q),
  .cmp         (cmp_q),
  .flag        (flag_q),
  .ren         (ren_q)
);

// File: tb/refresh_pacer_test.sv
module refresh_pacer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        refresh_ack = 1'b0;
  logic        refresh_req, irq;

  int total = 0;
  int bad = 0;
  int n_irq = 0;
  int n_ack = 0;

  always #5 clk = ~clk;

  refresh_pacer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .refresh_ack(refresh_ack), .refresh_req(refresh_req), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 write, 1 read-check, 2 ticks, 3 unused
    logic [1:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 2'd2, 32'h0, 32'h0, 4'd8},           // R8 constant resets to 0
    '{2'd1, 2'd0, 32'h0, 32'h0, 4'd8},           // R8 control resets to 0
    '{2'd1, 2'd1, 32'h0, 32'h0, 4'd8},           // R8 counter resets to 0
    '{2'd0, 2'd2, 32'h0000_0005, 32'h0, 4'd7},   // R7 no key
    '{2'd1, 2'd2, 32'h0, 32'h0, 4'd7},           // R7 rejected
    '{2'd0, 2'd2, 32'hA55A_0005, 32'h0, 4'd7},
    '{2'd1, 2'd2, 32'h0, 32'h5, 4'd8},           // R8 constant r/w
    '{2'd0, 2'd2, 32'hA55A_FF03, 32'h0, 4'd8},
    '{2'd1, 2'd2, 32'h0, 32'h3, 4'd8},           // R8 upper bits read 0
    '{2'd0, 2'd0, 32'hA55A_0003, 32'h0, 4'd8},
    '{2'd1, 2'd0, 32'h0, 32'h3, 4'd8},           // R8 enables
    '{2'd2, 2'd0, 32'd3, 32'h0, 4'd1},
    '{2'd1, 2'd1, 32'h0, 32'h3, 4'd1},           // R1 counted 3
    '{2'd1, 2'd0, 32'h0, 32'h3, 4'd2},           // R2 no flag yet
    '{2'd2, 2'd0, 32'd1, 32'h0, 4'd2},
    '{2'd1, 2'd0, 32'h0, 32'h7, 4'd2},           // R2 flag set
    '{2'd1, 2'd1, 32'h0, 32'h0, 4'd2},           // R2 counter cleared
    '{2'd0, 2'd0, 32'hA55A_0007, 32'h0, 4'd6},
    '{2'd1, 2'd0, 32'h0, 32'h7, 4'd6},           // R6 writing 1 keeps flag
    '{2'd0, 2'd0, 32'h1234_0003, 32'h0, 4'd7},
    '{2'd1, 2'd0, 32'h0, 32'h7, 4'd7},           // R7 bad key no clear
    '{2'd0, 2'd0, 32'hA55A_0003, 32'h0, 4'd6},
    '{2'd1, 2'd0, 32'h0, 32'h3, 4'd6},           // R6 flag cleared
    '{2'd0, 2'd1, 32'hA55A_0055, 32'h0, 4'd8},
    '{2'd1, 2'd1, 32'h0, 32'h0, 4'd8},           // R8 counter read-only
    '{2'd2, 2'd0, 32'd2, 32'h0, 4'd1},
    '{2'd0, 2'd2, 32'hA55A_0001, 32'h0, 4'd1},
    '{2'd2, 2'd0, 32'd254, 32'h0, 4'd1},
    '{2'd1, 2'd1, 32'h0, 32'h0, 4'd1},           // R1 wrapped 255->0
    '{2'd1, 2'd0, 32'h0, 32'h3, 4'd1},           // R1 wrap sets no flag
    '{2'd2, 2'd0, 32'd1, 32'h0, 4'd1},
    '{2'd1, 2'd1, 32'h0, 32'h1, 4'd1},
    '{2'd2, 2'd0, 32'd1, 32'h0, 4'd2},
    '{2'd1, 2'd0, 32'h0, 32'h7, 4'd2},           // R2 match after wrap
    '{2'd1, 2'd3, 32'h0, 32'h0, 4'd8}            // R8 unmapped reads 0
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_at(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic run_ticks(input int n);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulse_ack();
    refresh_ack = 1'b1;
    @(posedge clk); @(negedge clk);
    refresh_ack = 1'b0;
    n_ack++;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R3 reset req", {31'b0, refresh_req}, 32'h0);
    check("R6 reset irq", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        2'd0: bus_write(VECS[i].addr, VECS[i].data);
        2'd1: begin
          read_at(VECS[i].addr, rd);
          check($sformatf("R%0d vector %0d", VECS[i].tag, i), rd, VECS[i].exp);
        end
        2'd2: run_ticks(int'(VECS[i].data));
        default: ;
      endcase
    end

    #1;
    check("R3 req held unserved", {31'b0, refresh_req}, 32'h1);
    check("R6 irq from flag", {31'b0, irq}, 32'h1);
    pulse_ack(); #1;
    check("R4 ack clears req", {31'b0, refresh_req}, 32'h0);
    bus_write(2'd0, 32'hA55A_0003); #1;
    check("R6 clear drops irq", {31'b0, irq}, 32'h0);

    // R4: two matches, one ack
    bus_write(2'd2, 32'hA55A_0002);
    n_ack = 0;
    run_ticks(3); run_ticks(3); #1;
    check("R4 req after two matches", {31'b0, refresh_req}, 32'h1);
    pulse_ack();
    repeat (5) @(negedge clk);
    #1;
    check("R4 no queued second req", {31'b0, refresh_req}, 32'h0);
    check("R4 one ack served two matches", n_ack, 1);

    // R6: flag clear leaves req
    run_ticks(3); #1;
    check("R3 req on match", {31'b0, refresh_req}, 32'h1);
    bus_write(2'd0, 32'hA55A_0003); #1;
    check("R6 irq cleared", {31'b0, irq}, 32'h0);
    check("R6 req kept by flag clear", {31'b0, refresh_req}, 32'h1);
    pulse_ack();

    // R5: ack and match in the same cycle
    run_ticks(2);
    tick = 1'b1; refresh_ack = 1'b1;
    @(posedge clk); @(negedge clk);
    tick = 1'b0; refresh_ack = 1'b0; #1;
    check("R5 match wins over ack", {31'b0, refresh_req}, 32'h1);
    pulse_ack();
    bus_write(2'd0, 32'hA55A_0003);

    // R9: refresh disabled
    bus_write(2'd0, 32'hA55A_0002);
    run_ticks(3); #1;
    check("R9 irq without refresh", {31'b0, irq}, 32'h1);
    check("R9 no req when disabled", {31'b0, refresh_req}, 32'h0);
    bus_write(2'd0, 32'hA55A_0002);

    // R6: interrupt disabled
    bus_write(2'd0, 32'hA55A_0001);
    run_ticks(3); #1;
    check("R6 no irq when disabled", {31'b0, irq}, 32'h0);
    read_at(2'd0, rd);
    check("R6 flag set while irq masked", rd, 32'h5);
    pulse_ack();
    bus_write(2'd0, 32'hA55A_0001);

    // R3/R6: request count against interrupt count over many periods
    bus_write(2'd2, 32'hA55A_0004);
    bus_write(2'd0, 32'hA55A_0003);
    n_ack = 0; n_irq = 0;
    for (int p = 0; p < 40; p++) begin
      run_ticks(4); #1;
      if (irq || refresh_req) begin
        total++; bad++;
        $display("FAIL R2 early match period %0d actual=%b%b expected=00", p, irq, refresh_req);
      end
      run_ticks(1); #1;
      if (irq) n_irq++;
      if (refresh_req) pulse_ack();
      bus_write(2'd0, 32'hA55A_0003);
    end
    check("R3 requests per period", n_ack, 40);
    check("R6 interrupts per period", n_irq, 40);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule